// File: doc/BRIEF.md
# Line-Card Relay Switch State Controller

This block is the digital control core of a solid-state replacement for the relay on a telephone line card. It decides which of four switches are closed: two line-break switches that join the subscriber pair to the line driver, a ringing-return switch, and a ringing switch that joins the ringing generator. A ringing-select input chooses between the talk and ringing connections. A latch-enable input freezes that choice. An active-low shutdown input forces every switch open, and the latch does not hold it.

Two monitors can also force all switches open. The first watches a signed digitized battery voltage and has hysteresis between -10 V and -15 V. The second watches a digitized die temperature and has a programmable hysteresis; while it is tripped, it pulls an active-low status output low. The ringing switch opens only on a zero-current-crossing strobe from the ringing path. Because of this, leaving ringing by dropping the select gives make-before-break sequencing, and leaving it by pulling shutdown low gives break-before-make.

Top module: `line_switch_ctrl`

## Requirements
- R1: The switch outputs, read as {brkTipEn, brkRingEn, ringRetEn, ringEn}, take these values in steady state: 4'b1100 in talk, 4'b0011 in ringing and 4'b0000 in all-off. Both line-break enables are never 1 at the same time as ringRetEn.
- R2: Outputs are registered. When nothing forces all-off and the latch is transparent, ringSel=1 selects ringing and ringSel=0 selects talk, one clock edge after the inputs are sampled.
- R3: While latchEn=0 the select passes straight through. While latchEn=1 the block uses the ringSel value sampled in the last cycle that latchEn was 0, and ignores later changes of ringSel.
- R4: shdnN=0 forces all-off on the next edge, whatever ringSel and latchEn are. It does not pass through the latch, so the latched select is still in effect once shdnN returns to 1.
- R5: Once ringEn is 1, a command that would clear it takes effect only on an edge where zeroCross=1. Until then ringEn stays 1, whatever the inputs are. A zeroCross pulse has no effect when no such command is pending.
- R6: Make-before-break: if ringSel drops to 0 during ringing, the outputs become 4'b1101 on the next edge and 4'b1100 after the zero crossing.
- R7: Break-before-make: if shdnN drops during ringing, the outputs become 4'b0001 on the next edge and 4'b0000 after the zero crossing. If shdnN is then released with ringSel=0, the outputs return to talk.
- R8: A battery fault is set when batMv > -10000 mV and cleared when batMv < -15000 mV. Both bounds are exclusive, and the value is held in between. The fault register updates one edge after the sample, and the switches go to all-off one edge after that.
- R9: A thermal fault is set when dieTemp >= 110 and cleared when dieTemp <= 110 - TEMP_HYST, where TEMP_HYST defaults to 15. shdnStatN is 0 exactly while the fault is set, one edge after the sample, and the switches go to all-off one edge after that.
- R10: While reset is active, the switch enables are 0, shdnStatN is 1, the latch holds 0 and no ringing-switch turn-off is pending.
- R11: If zeroCross=1 in the same cycle as the first command to open the ringing switch, the ringing switch opens on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ringSel | input | 1 | 1 selects ringing, 0 selects talk |
| latchEn | input | 1 | 0 makes the latch transparent, 1 holds the select |
| shdnN | input | 1 | Active-low forced all-off, not latched |
| zeroCross | input | 1 | Single-cycle zero-current-crossing strobe |
| batMv | input | BAT_W (17) | Signed battery voltage in millivolts |
| dieTemp | input | TEMP_W (9) | Die temperature in degrees C |
| brkTipEn | output | 1 | Tip line-break switch enable |
| brkRingEn | output | 1 | Ring line-break switch enable |
| ringRetEn | output | 1 | Ringing-return switch enable |
| ringEn | output | 1 | Ringing switch enable |
| shdnStatN | output | 1 | Low while in thermal shutdown |

## Verification
The command that opens the ringing switch and the zero-crossing strobe can arrive in the same cycle. The bench provokes this by dropping ringSel and raising zeroCross on the same falling edge. It then requires pure talk after a single rising edge, with no 4'b1101 step in between. It also sends strobes while in talk and while the ringing switch is already being held in ringing, and requires the outputs to stay the same. The hysteresis bands of both monitors are probed at their exact bounds.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TALK = 2'd1,
    ST_RING = 2'd2
  } lscStateT;

  // strobes from the input datapath to the switch control
  typedef struct packed {
    logic forceOff;
    logic wantRing;
  } lscCmdT;

endpackage

// File: rtl/lsc_monitor.sv
module lsc_monitor
  import lsc_pkg::*;
#(
  parameter int BAT_W        = 17,
  parameter int TEMP_W       = 9,
  parameter int BAT_TRIP_MV  = -10000,
  parameter int BAT_CLEAR_MV = -15000,
  parameter int TEMP_TRIP    = 110,
  parameter int TEMP_HYST    = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ringSel,
  input  logic                    latchEn,
  input  logic                    shdnN,
  input  logic signed [BAT_W-1:0] batMv,
  input  logic [TEMP_W-1:0]       dieTemp,
  output lscCmdT                  cmd,
  output logic                    thermHot
);

  localparam int TEMP_CLEAR = TEMP_TRIP - TEMP_HYST;

  logic heldSel;
  logic batFault;
  logic selNow;
  int   batInt;
  int   tempInt;

  assign batInt  = int'(batMv);
  assign tempInt = int'({1'b0, dieTemp});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSel <= 1'b0;
    end else if (!latchEn) begin
      heldSel <= ringSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      batFault <= 1'b0;
    end else if (batInt > BAT_TRIP_MV) begin
      batFault <= 1'b1;
    end else if (batInt < BAT_CLEAR_MV) begin
      batFault <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermHot <= 1'b0;
    end else if (tempInt >= TEMP_TRIP) begin
      thermHot <= 1'b1;
    end else if (tempInt <= TEMP_CLEAR) begin
      thermHot <= 1'b0;
    end
  end

  assign selNow       = latchEn ? heldSel : ringSel;
  assign cmd.forceOff = !shdnN || batFault || thermHot;
  assign cmd.wantRing = selNow;

endmodule

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  lscCmdT cmd,
  input  logic   zeroCross,
  output logic   brkEn,
  output logic   ringRetOn,
  output logic   ringOn
);

  lscStateT stateQ;
  lscStateT stateD;
  logic     ringD;

  always_comb begin
    if (cmd.forceOff) begin
      stateD = ST_OFF;
    end else if (cmd.wantRing) begin
      stateD = ST_RING;
    end else begin
      stateD = ST_TALK;
    end
  end

  // the ringing switch may only open on a zero-current crossing
  always_comb begin
    if (stateD == ST_RING) begin
      ringD = 1'b1;
    end else if (ringOn && !zeroCross) begin
      ringD = 1'b1;
    end else begin
      ringD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      ringOn <= 1'b0;
    end else begin
      stateQ <= stateD;
      ringOn <= ringD;
    end
  end

  assign brkEn     = (stateQ == ST_TALK);
  assign ringRetOn = (stateQ == ST_RING);

endmodule

// File: rtl/line_switch_ctrl.sv
module line_switch_ctrl
  import lsc_pkg::*;
#(
  parameter int BAT_W     = 17,
  parameter int TEMP_W    = 9,
  parameter int TEMP_HYST = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ringSel,
  input  logic                    latchEn,
  input  logic                    shdnN,
  input  logic                    zeroCross,
  input  logic signed [BAT_W-1:0] batMv,
  input  logic [TEMP_W-1:0]       dieTemp,
  output logic                    brkTipEn,
  output logic                    brkRingEn,
  output logic                    ringRetEn,
  output logic                    ringEn,
  output logic                    shdnStatN
);

  lscCmdT cmd;
  logic   thermHot;
  logic   brkEn;

  lsc_monitor #(
    .BAT_W(BAT_W), .TEMP_W(TEMP_W), .BAT_TRIP_MV(-10000),
    .BAT_CLEAR_MV(-15000), .TEMP_TRIP(110), .TEMP_HYST(TEMP_HYST)
  ) i_monitor (
    .clk(clk), .rstN(rstN), .ringSel(ringSel), .latchEn(latchEn),
    .shdnN(shdnN), .batMv(batMv), .dieTemp(dieTemp),
    .cmd(cmd), .thermHot(thermHot)
  );

  lsc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmd(cmd), .zeroCross(zeroCross),
    .brkEn(brkEn), .ringRetOn(ringRetEn), .ringOn(ringEn)
  );

  assign brkTipEn  = brkEn;
  assign brkRingEn = brkEn;
  assign shdnStatN = !thermHot;

endmodule

// File: rtl/lsc_checker.sv
module lsc_checker (
  input logic clk,
  input logic rstN,
  input logic shdnN,
  input logic zeroCross,
  input logic brkTipEn,
  input logic brkRingEn,
  input logic ringRetEn,
  input logic ringEn,
  input logic shdnStatN
);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !((brkTipEn || brkRingEn) && ringRetEn));

  a_r4_shdn_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |=> (!brkTipEn && !brkRingEn && !ringRetEn));

  a_r5_ring_held: assert property (@(posedge clk) disable iff (!rstN)
    (ringEn && !zeroCross) |=> ringEn);

  a_r1_ring_with_return: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ringEn) |-> ringRetEn);

  a_r9_hot_forces_off: assert property (@(posedge clk) disable iff (!rstN)
    !shdnStatN |=> (!brkTipEn && !ringRetEn));

endmodule

bind line_switch_ctrl lsc_checker i_chk (
  .clk(clk), .rstN(rstN), .shdnN(shdnN), .zeroCross(zeroCross),
  .brkTipEn(brkTipEn), .brkRingEn(brkRingEn), .ringRetEn(ringRetEn),
  .ringEn(ringEn), .shdnStatN(shdnStatN)
);

// File: tb/test_line_switch_ctrl.sv
module test_line_switch_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [3:0] TALK = 4'b1100;
  localparam logic [3:0] RING = 4'b0011;
  localparam logic [3:0] OFF  = 4'b0000;
  localparam logic [3:0] MBB  = 4'b1101;
  localparam logic [3:0] BBM  = 4'b0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ringSel = 1'b0;
  logic latchEn = 1'b0;
  logic shdnN = 1'b1;
  logic zeroCross = 1'b0;
  logic signed [16:0] batMv = -17'sd48000;
  logic [8:0] dieTemp = 9'd25;
  logic brkTipEn, brkRingEn, ringRetEn, ringEn, shdnStatN;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_switch_ctrl i_line_switch_ctrl (
    .clk(clk), .rstN(rstN), .ringSel(ringSel), .latchEn(latchEn),
    .shdnN(shdnN), .zeroCross(zeroCross), .batMv(batMv), .dieTemp(dieTemp),
    .brkTipEn(brkTipEn), .brkRingEn(brkRingEn), .ringRetEn(ringRetEn),
    .ringEn(ringEn), .shdnStatN(shdnStatN)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkSw(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {brkTipEn, brkRingEn, ringRetEn, ringEn};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s switches act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkStat(input string req, input logic exp);
    total++;
    if (shdnStatN !== exp) begin
      bad++;
      $display("FAIL %s shdnStatN act=%b exp=%b at %0t", req, shdnStatN, exp, $time);
    end
  endtask

  task automatic zcPulse();
    zeroCross = 1'b1;
    step(1);
    zeroCross = 1'b0;
  endtask

  task automatic testReset();
    step(2);
    chkSw("R10", OFF);
    chkStat("R10", 1'b1);
    rstN = 1'b1;
    step(1);
    chkSw("R2", TALK);
  endtask

  task automatic testMbb();
    ringSel = 1'b1;
    step(1);
    chkSw("R2", RING);
    zcPulse();
    chkSw("R5", RING);                 // strobe while still ringing: no change
    ringSel = 1'b0;
    step(1);
    chkSw("R6", MBB);
    step(3);
    chkSw("R5", MBB);
    zcPulse();
    chkSw("R6", TALK);
    zcPulse();
    chkSw("R5", TALK);
  endtask

  task automatic testBbm();
    ringSel = 1'b1;
    step(1);
    chkSw("R1", RING);
    shdnN = 1'b0;
    ringSel = 1'b0;
    step(1);
    chkSw("R7", BBM);
    step(2);
    chkSw("R7", BBM);
    zcPulse();
    chkSw("R7", OFF);
    shdnN = 1'b1;
    step(1);
    chkSw("R7", TALK);
  endtask

  task automatic testSameCycle();
    ringSel = 1'b1;
    step(1);
    ringSel = 1'b0;
    zeroCross = 1'b1;
    step(1);
    zeroCross = 1'b0;
    chkSw("R11", TALK);
  endtask

  task automatic testLatch();
    latchEn = 1'b1;
    step(1);
    ringSel = 1'b1;
    step(2);
    chkSw("R3", TALK);
    latchEn = 1'b0;
    step(1);
    chkSw("R3", RING);
    latchEn = 1'b1;
    step(1);
    ringSel = 1'b0;
    step(2);
    chkSw("R3", RING);
    shdnN = 1'b0;
    step(1);
    chkSw("R4", BBM);
    zcPulse();
    chkSw("R4", OFF);
    shdnN = 1'b1;
    step(1);
    chkSw("R4", RING);
    latchEn = 1'b0;
    step(1);
    chkSw("R3", MBB);
    zcPulse();
    chkSw("R3", TALK);
  endtask

  task automatic testBattery();
    batMv = -17'sd10000;
    step(2);
    chkSw("R8", TALK);
    batMv = -17'sd9999;
    step(1);
    chkSw("R8", TALK);
    step(1);
    chkSw("R8", OFF);
    batMv = -17'sd12000;
    step(2);
    chkSw("R8", OFF);
    batMv = -17'sd15000;
    step(2);
    chkSw("R8", OFF);
    batMv = -17'sd15001;
    step(2);
    chkSw("R8", TALK);
    batMv = -17'sd48000;
  endtask

  task automatic testThermal();
    dieTemp = 9'd109;
    step(2);
    chkSw("R9", TALK);
    chkStat("R9", 1'b1);
    dieTemp = 9'd110;
    step(1);
    chkStat("R9", 1'b0);
    chkSw("R9", TALK);
    step(1);
    chkSw("R9", OFF);
    dieTemp = 9'd96;
    step(2);
    chkStat("R9", 1'b0);
    chkSw("R9", OFF);
    dieTemp = 9'd95;
    step(1);
    chkStat("R9", 1'b1);
    step(1);
    chkSw("R9", TALK);
    dieTemp = 9'd25;
  endtask

  initial begin
    testReset();
    testMbb();
    testBbm();
    testSameCycle();
    testLatch();
    testBattery();
    testThermal();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule